// File: doc/BRIEF.md
# Instruction Fetch and Branch-Hazard Controller

This block is the front end of a five-stage integer pipeline. It owns the program counter and the register between fetch and decode. It reads instruction memory through a combinational port, addressed directly by the program counter. On every clock edge it does one of three things. It fetches the next sequential word. It holds both the counter and the fetch/decode register because decode asked for a stall. Or it loads a bubble, which is an empty slot that the later stages treat as a no-op.

A two-bit run-time input selects how conditional branches and register jumps in decode are handled. The freeze and predict-taken strategies put a bubble behind the branch. The predict-not-taken and delay-slot strategies keep fetching in sequence. Target computation and branch resolution happen elsewhere; a resolved redirect arrives as an input together with its target address. Decode also reports whether the branch's source register still has a write pending. In that case the branch waits in decode, and the fetch side waits with it.

Top module: `fetch_ctl`

## Requirements
- R1: While reset is asserted and right after it is released, the PC and `imem_addr_o` equal `START_PC`, the slot status is 2 (idle), and the fetched word and next-PC outputs are 0.
- R2: A normal fetch does the following. It latches the memory word read at the current PC into the fetch/decode register. It latches PC+4 (modulo 2^AW) as the next-PC. It reports status 0 (normal) and advances the PC by 4.
- R3: A cycle with `stall_i` high and no redirect holds the PC, the fetched word and the next-PC unchanged, and reports status 1 (stall). The first cycle without a stall resumes normal fetching.
- R4: A branch in decode (`branch_i`) whose source register has a pending write (`rs_pend_i`) causes the stall behaviour of R3 in all four strategy modes.
- R5: In mode 0 (freeze) and mode 1 (predict-taken), a branch in decode with no pending source write does three things. It clears the fetched word and next-PC to 0. It reports status 2 (idle). It holds the PC.
- R6: In mode 2 (predict-not-taken) and mode 3 (delay slot), a branch in decode with no pending source write fetches normally, as in R2.
- R7: When `redirect_i` is high, the PC loads `redirect_pc_i` on that edge. This takes priority over stall and branch inputs.
- R8: On a redirect in mode 3, the fetch/decode register captures the sequential word as a normal fetch (status 0). In modes 0, 1 and 2 it becomes a bubble (word 0, next-PC 0, status 2).
- R9: The PC wraps modulo 2^AW: a normal fetch at address 2^AW-4 gives a next-PC of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_mode_i | input | 2 | Branch strategy: 0 freeze, 1 predict-taken, 2 predict-not-taken, 3 delay slot |
| stall_i | input | 1 | Stall request from decode |
| branch_i | input | 1 | Decode holds a conditional branch or register jump |
| rs_pend_i | input | 1 | Source register of the branch has a pending write |
| redirect_i | input | 1 | Resolved redirect, load the PC with the target |
| redirect_pc_i | input | AW | Redirect target address |
| imem_addr_o | output | AW | Instruction memory address (current PC) |
| imem_data_i | input | DW | Instruction memory read data, combinational |
| ifid_instr_o | output | DW | Instruction word held in the fetch/decode register |
| ifid_npc_o | output | AW | Next-PC held in the fetch/decode register |
| ifid_stat_o | output | 2 | Slot status: 0 normal, 1 stall, 2 idle |

## Verification
The bench builds the block with AW=16, DW=32 and START_PC=0x0040. The narrow 16-bit address lets a single redirect to 0xFFFC reach the wrap-around boundary of R9. The non-zero start address makes the reset value distinct from a cleared register. The bench's memory model returns a word that contains its own address. Every latched instruction therefore shows which PC it was fetched from, so a hold, a bubble and a redirect can each be told apart.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    // Status code of the fetch/decode slot
    typedef enum logic [1:0] {
        ST_NORM  = 2'd0,
        ST_STALL = 2'd1,
        ST_IDLE  = 2'd2
    } slot_st_e;

    // Run-time branch strategy
    typedef enum logic [1:0] {
        BR_FREEZE   = 2'd0,
        BR_TAKEN    = 2'd1,
        BR_NOTTAKEN = 2'd2,
        BR_DELAY    = 2'd3
    } br_mode_e;

    // What the slot register does this edge
    typedef enum logic [1:0] {
        SL_FETCH  = 2'd0,
        SL_HOLD   = 2'd1,
        SL_BUBBLE = 2'd2
    } slot_act_e;

    // What the program counter does this edge
    typedef enum logic [1:0] {
        PC_INC  = 2'd0,
        PC_HOLD = 2'd1,
        PC_LOAD = 2'd2
    } pc_act_e;

    typedef struct packed {
        slot_act_e slot;
        pc_act_e   pc;
    } fetch_act_t;

endpackage

// File: rtl/fetch_hazard.sv
module fetch_hazard
    import fetch_pkg::*;
(
    input  br_mode_e   mode_i,
    input  logic       stall_i,
    input  logic       branch_i,
    input  logic       rs_pend_i,
    input  logic       redirect_i,
    output fetch_act_t act_o
);

    logic hold_req;
    logic bubble_mode;

    always_comb begin
        hold_req    = stall_i | (branch_i & rs_pend_i);
        bubble_mode = (mode_i == BR_FREEZE) || (mode_i == BR_TAKEN);

        act_o.slot = SL_FETCH;
        act_o.pc   = PC_INC;

        if (redirect_i) begin
            act_o.pc   = PC_LOAD;
            act_o.slot = (mode_i == BR_DELAY) ? SL_FETCH : SL_BUBBLE;
        end else if (hold_req) begin
            act_o.pc   = PC_HOLD;
            act_o.slot = SL_HOLD;
        end else if (branch_i && bubble_mode) begin
            act_o.pc   = PC_HOLD;
            act_o.slot = SL_BUBBLE;
        end
    end

endmodule

// File: rtl/fetch_pc.sv
module fetch_pc
    import fetch_pkg::*;
#(
    parameter int            AW       = 32,
    parameter int            STEP     = 4,
    parameter logic [AW-1:0] START_PC = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  pc_act_e       sel_i,
    input  logic [AW-1:0] inc_i,
    input  logic [AW-1:0] tgt_i,
    output logic [AW-1:0] pc_o
);

    typedef struct packed {
        logic [AW-1:0] pc;
    } pc_reg_t;

    pc_reg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (sel_i)
            PC_INC:  st_d.pc = inc_i;
            PC_LOAD: st_d.pc = tgt_i;
            default: st_d.pc = st_q.pc;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.pc <= START_PC;
        else        st_q    <= st_d;
    end

    assign pc_o = st_q.pc;

    // R2 / R9: an increment advances by one word, wrapping modulo 2^AW
    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        sel_i == PC_INC |=> st_q.pc == $past(st_q.pc) + AW'(STEP));

    // R3: a held PC does not move
    a_r3_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        sel_i == PC_HOLD |=> $stable(st_q.pc));

endmodule

// File: rtl/fetch_ifid.sv
module fetch_ifid
    import fetch_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  slot_act_e     act_i,
    input  logic [DW-1:0] instr_i,
    input  logic [AW-1:0] npc_i,
    output logic [DW-1:0] instr_o,
    output logic [AW-1:0] npc_o,
    output slot_st_e      stat_o
);

    typedef struct packed {
        logic [DW-1:0] instr;
        logic [AW-1:0] npc;
        slot_st_e      stat;
    } slot_reg_t;

    slot_reg_t sl_d, sl_q;

    always_comb begin
        sl_d = sl_q;
        case (act_i)
            SL_FETCH: begin
                sl_d.instr = instr_i;
                sl_d.npc   = npc_i;
                sl_d.stat  = ST_NORM;
            end
            SL_HOLD: begin
                sl_d.stat  = ST_STALL;
            end
            default: begin
                sl_d.instr = '0;
                sl_d.npc   = '0;
                sl_d.stat  = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sl_q.instr <= '0;
            sl_q.npc   <= '0;
            sl_q.stat  <= ST_IDLE;
        end else begin
            sl_q <= sl_d;
        end
    end

    assign instr_o = sl_q.instr;
    assign npc_o   = sl_q.npc;
    assign stat_o  = sl_q.stat;

    // R3: a stalled slot keeps its contents and reports stall
    a_r3_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        act_i == SL_HOLD |=> $stable(sl_q.instr) && $stable(sl_q.npc) && sl_q.stat == ST_STALL);

    // R5: a bubble empties the slot
    a_r5_bubble_clear: assert property (@(posedge clk) disable iff (!rst_n)
        act_i == SL_BUBBLE |=> sl_q.instr == '0 && sl_q.npc == '0 && sl_q.stat == ST_IDLE);

endmodule

// File: rtl/fetch_ctl.sv
module fetch_ctl
    import fetch_pkg::*;
#(
    parameter int            AW       = 32,
    parameter int            DW       = 32,
    parameter logic [AW-1:0] START_PC = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    br_mode_i,
    input  logic          stall_i,
    input  logic          branch_i,
    input  logic          rs_pend_i,
    input  logic          redirect_i,
    input  logic [AW-1:0] redirect_pc_i,
    output logic [AW-1:0] imem_addr_o,
    input  logic [DW-1:0] imem_data_i,
    output logic [DW-1:0] ifid_instr_o,
    output logic [AW-1:0] ifid_npc_o,
    output logic [1:0]    ifid_stat_o
);

    localparam int STEP = DW / 8;

    fetch_act_t    act;
    logic [AW-1:0] pc_q;
    logic [AW-1:0] pc_inc;
    slot_st_e      stat;

    assign pc_inc = pc_q + AW'(STEP);

    fetch_hazard u_haz (
        .mode_i     (br_mode_e'(br_mode_i)),
        .stall_i    (stall_i),
        .branch_i   (branch_i),
        .rs_pend_i  (rs_pend_i),
        .redirect_i (redirect_i),
        .act_o      (act)
    );

    fetch_pc #(.AW(AW), .STEP(STEP), .START_PC(START_PC)) u_pc (
        .clk   (clk),
        .rst_n (rst_n),
        .sel_i (act.pc),
        .inc_i (pc_inc),
        .tgt_i (redirect_pc_i),
        .pc_o  (pc_q)
    );

    fetch_ifid #(.AW(AW), .DW(DW)) u_ifid (
        .clk     (clk),
        .rst_n   (rst_n),
        .act_i   (act.slot),
        .instr_i (imem_data_i),
        .npc_i   (pc_inc),
        .instr_o (ifid_instr_o),
        .npc_o   (ifid_npc_o),
        .stat_o  (stat)
    );

    assign imem_addr_o = pc_q;
    assign ifid_stat_o = stat;

    // R7: a redirect loads the target whatever else is requested
    a_r7_redirect_load: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_i |=> imem_addr_o == $past(redirect_pc_i));

    // R4: a branch waiting on its source register stalls the slot
    a_r4_branch_wait: assert property (@(posedge clk) disable iff (!rst_n)
        branch_i && rs_pend_i && !redirect_i |=> ifid_stat_o == 2'd1);

    // R6: sequential strategies keep fetching past a ready branch
    a_r6_seq_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        branch_i && !rs_pend_i && !stall_i && !redirect_i && br_mode_i[1]
        |=> ifid_stat_o == 2'd0 && ifid_instr_o == $past(imem_data_i));

    // R8: delay-slot redirect keeps the sequential word
    a_r8_delay_keep: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_i && br_mode_i == 2'd3 |=> ifid_stat_o == 2'd0);

endmodule

// File: tb/sim_fetch_ctl.sv
module sim_fetch_ctl;

    localparam int            AW   = 16;
    localparam int            DW   = 32;
    localparam logic [AW-1:0] BOOT = 16'h0040;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic          stall = 1'b0;
    logic          branch = 1'b0;
    logic          rs_pend = 1'b0;
    logic          redir = 1'b0;
    logic [AW-1:0] redir_pc = '0;
    logic [AW-1:0] addr;
    logic [DW-1:0] rdata;
    logic [DW-1:0] instr;
    logic [AW-1:0] npc;
    logic [1:0]    stat;

    int n_chk = 0;
    int n_bad = 0;
    logic [AW-1:0] exp_pc;

    always #5 clk = ~clk;

    function automatic logic [DW-1:0] word_at(input logic [AW-1:0] a);
        return {16'hC0DE, a};
    endfunction

    assign rdata = word_at(addr);

    fetch_ctl #(.AW(AW), .DW(DW), .START_PC(BOOT)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .br_mode_i     (mode),
        .stall_i       (stall),
        .branch_i      (branch),
        .rs_pend_i     (rs_pend),
        .redirect_i    (redir),
        .redirect_pc_i (redir_pc),
        .imem_addr_o   (addr),
        .imem_data_i   (rdata),
        .ifid_instr_o  (instr),
        .ifid_npc_o    (npc),
        .ifid_stat_o   (stat)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        stall = 0; branch = 0; rs_pend = 0; redir = 0;
    endtask

    task automatic expect_fetch(input string req, input logic [AW-1:0] from);
        chk(req, "instr", instr, word_at(from));
        chk(req, "npc", 32'(npc), 32'(AW'(from + 4)));
        chk(req, "stat", 32'(stat), 32'd0);
    endtask

    task automatic expect_bubble(input string req);
        chk(req, "instr", instr, '0);
        chk(req, "npc", 32'(npc), 32'd0);
        chk(req, "stat", 32'(stat), 32'd2);
    endtask

    task automatic t_reset();
        rst_n = 0;
        step(); step();
        chk("R1", "pc in reset", 32'(addr), 32'(BOOT));
        expect_bubble("R1");
        rst_n = 1;
        #2;
        chk("R1", "pc after release", 32'(addr), 32'(BOOT));
        chk("R1", "stat after release", 32'(stat), 32'd2);
        exp_pc = BOOT;
    endtask

    task automatic t_normal();
        idle_inputs();
        for (int i = 0; i < 3; i++) begin
            logic [AW-1:0] p;
            p = exp_pc;
            step();
            expect_fetch("R2", p);
            exp_pc = p + 4;
            chk("R2", "pc advance", 32'(addr), 32'(exp_pc));
        end
    endtask

    task automatic t_stall();
        logic [DW-1:0] held;
        held = instr;
        stall = 1;
        step();
        chk("R3", "instr held", instr, held);
        chk("R3", "stat", 32'(stat), 32'd1);
        chk("R3", "pc held", 32'(addr), 32'(exp_pc));
        stall = 0;
        step();
        expect_fetch("R3", exp_pc);
        exp_pc = exp_pc + 4;
    endtask

    task automatic t_branch_wait();
        for (int m = 0; m < 4; m++) begin
            logic [DW-1:0] held;
            held = instr;
            mode = 2'(m); branch = 1; rs_pend = 1;
            step();
            chk("R4", "stat", 32'(stat), 32'd1);
            chk("R4", "instr held", instr, held);
            chk("R4", "pc held", 32'(addr), 32'(exp_pc));
        end
        idle_inputs();
        step();
        exp_pc = exp_pc + 4;
    endtask

    task automatic t_branch_bubble();
        for (int m = 0; m < 2; m++) begin
            mode = 2'(m); branch = 1; rs_pend = 0;
            step();
            expect_bubble("R5");
            chk("R5", "pc held", 32'(addr), 32'(exp_pc));
            branch = 0;
            step();
            expect_fetch("R5", exp_pc);
            exp_pc = exp_pc + 4;
        end
    endtask

    task automatic t_branch_seq();
        for (int m = 2; m < 4; m++) begin
            mode = 2'(m); branch = 1; rs_pend = 0;
            step();
            expect_fetch("R6", exp_pc);
            exp_pc = exp_pc + 4;
            chk("R6", "pc advance", 32'(addr), 32'(exp_pc));
        end
        idle_inputs();
    endtask

    task automatic t_redirect();
        logic [AW-1:0] p;
        mode = 2'd2; redir = 1; redir_pc = 16'h0200; stall = 1; branch = 1;
        step();
        chk("R7", "pc loaded over stall", 32'(addr), 32'h0200);
        expect_bubble("R8");
        idle_inputs();
        exp_pc = 16'h0200;
        mode = 2'd3;
        p = exp_pc;
        redir = 1; redir_pc = 16'h0300;
        step();
        chk("R7", "pc loaded", 32'(addr), 32'h0300);
        expect_fetch("R8", p);
        mode = 2'd0;
        redir_pc = 16'h0400;
        step();
        chk("R7", "pc loaded mode0", 32'(addr), 32'h0400);
        expect_bubble("R8");
        idle_inputs();
        exp_pc = 16'h0400;
    endtask

    task automatic t_wrap();
        redir = 1; redir_pc = 16'hFFFC; mode = 2'd3;
        step();
        redir = 0;
        step();
        expect_fetch("R9", 16'hFFFC);
        chk("R9", "pc wrap", 32'(addr), 32'h0000);
        chk("R9", "npc wrap", 32'(npc), 32'h0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_normal();
        t_stall();
        t_branch_wait();
        t_branch_bubble();
        t_branch_seq();
        t_redirect();
        t_wrap();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule